// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block keeps a 16-bit count driven by a single input pin and works in one of two modes. In edge mode, each active transition of the pin adds one to the count. In gated mode, a free-running divide-by-64 prescaler of the system clock adds one to the count on each of its ticks while the pin is at its active level. The result is the length of a pulse in units of 64 clocks.

Two sticky flags record activity:
- The wrap flag rises when the count rolls over from its all-ones value to zero.
- The edge flag rises on every counted edge in edge mode, and on the closing edge of the gate in gated mode.

Each flag has its own interrupt enable, and one interrupt line is the OR of the enabled flags. Software can load the count at any time. Loading the two's complement of N gives an interrupt after exactly N events. The pin passes through a two-flop synchronizer before any logic sees it.

Top module: `pulse_accum`

## Requirements
- R1: After reset, the count is 0, both flags are 0 and the interrupt line is 0.
- R2: The control write data is {edge_ie, wrap_ie, pol, mode, en}, with en in bit 0. With en=1 and mode=0 (edge mode), the count rises by one on each rising pin edge when pol=1, or on each falling pin edge when pol=0. The opposite edge leaves the count unchanged.
- R3: In edge mode, each counted edge sets the edge flag.
- R4: With en=1 and mode=1 (gated mode), the count rises by one for every 64 clock cycles the pin spends at its active level. The active level is high when pol=0 and low when pol=1. The count does not change while the pin is inactive.
- R5: In gated mode, the edge flag stays 0 when the pin enters its active level. It is set when the pin leaves the active level.
- R6: When an increment takes the count from 0xFFFF to 0x0000, the wrap flag is set.
- R7: A count write loads the count on the next clock edge. After a load of 0x10000-N, the wrap flag is still clear after N-1 counted edges and is set after the Nth.
- R8: A flag write clears the wrap flag when data bit 1 is 1, and clears the edge flag when data bit 0 is 1. A flag whose bit is 0 keeps its value.
- R9: The interrupt line is 1 exactly when (wrap flag AND wrap_ie) OR (edge flag AND edge_ie).
- R10: With en=0, pin activity in either mode changes neither the count nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous pulse input |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control data {edge_ie, wrap_ie, pol, mode, en} |
| cnt_wr | input | 1 | Count load strobe |
| cnt_wdata | input | 16 | Count load value |
| flg_wr | input | 1 | Flag clear strobe |
| flg_wdata | input | 2 | Bit 1 clears the wrap flag, bit 0 clears the edge flag |
| count_o | output | 16 | Current count |
| wrap_o | output | 1 | Wrap flag |
| edge_o | output | 1 | Edge flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the exact gated total, because the prescaler phase cannot be seen or set from the ports. The bench avoids the problem by holding the pin active for an exact multiple of 64 cycles. Any such window contains exactly that many prescaler ticks, whatever the phase. The wrap boundary is reached quickly by loading a count just below the top and then sending N-1 and N edges.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int CNT_W = 16;
  localparam int CTL_W = 5;

  typedef struct packed {
    logic edge_ie;
    logic wrap_ie;
    logic pol;
    logic mode;
    logic en;
  } pa_ctl_t;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q, div_d;

  always_comb begin
    div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    cnt_en = ld_i | inc_i;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (inc_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = (cnt_q == TOP);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int DIV      = 64,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             flg_wr,
  input  logic [1:0]       flg_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o,
  output logic             edge_o,
  output logic             irq_o
);
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  assign arst_n = rst_sync_q[1];

  pa_ctl_t ctl_q, ctl_d;
  logic    wrap_q, wrap_d, edge_q, edge_d;
  logic    lvl, rise, fall, tick, gate_on, edge_evt, inc, wrap_evt;

  pa_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(arst_n), .d_i(pin_i),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pa_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(arst_n), .tick_o(tick)
  );

  // Active edge in edge mode and closing edge of the gate share one select.
  always_comb begin
    gate_on  = ctl_q.pol ? ~lvl : lvl;
    edge_evt = ctl_q.en & (ctl_q.pol ? rise : fall);
    inc      = ctl_q.en & (ctl_q.mode ? (tick & gate_on) : edge_evt);
  end

  pa_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(arst_n), .inc_i(inc), .ld_i(cnt_wr),
    .ld_val_i(cnt_wdata), .cnt_o(count_o), .wrap_o(wrap_evt)
  );

  always_comb begin
    ctl_d = ctl_wr ? pa_ctl_t'(ctl_wdata) : ctl_q;
    wrap_d = wrap_q;
    if (wrap_evt)                   wrap_d = 1'b1;
    else if (flg_wr & flg_wdata[1]) wrap_d = 1'b0;
    edge_d = edge_q;
    if (edge_evt)                   edge_d = 1'b1;
    else if (flg_wr & flg_wdata[0]) edge_d = 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      ctl_q  <= '0;
      wrap_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      wrap_q <= wrap_d;
      edge_q <= edge_d;
    end

  assign wrap_o = wrap_q;
  assign edge_o = edge_q;
  assign irq_o  = (wrap_q & ctl_q.wrap_ie) | (edge_q & ctl_q.edge_ie);
endmodule

// File: rtl/pa_checker.sv
module pa_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        cnt_wr,
  input logic [15:0] cnt_wdata,
  input logic        flg_wr,
  input logic [1:0]  flg_wdata,
  input logic [15:0] count_o,
  input logic        wrap_o,
  input logic        edge_o,
  input logic        irq_o
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_wr) && !$stable(count_o)) |-> (count_o == 16'($past(count_o) + 16'd1)));

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_o) |-> (count_o == 16'd0));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_o == $past(cnt_wdata)));

  p_wrap_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wrap_o) |-> $past(flg_wr && flg_wdata[1]));

  p_edge_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edge_o) |-> $past(flg_wr && flg_wdata[0]));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_o && !edge_o) |-> !irq_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!en) && !$past(cnt_wr)) |-> $stable(count_o));
endmodule

bind pulse_accum pa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_q.en),
  .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .flg_wr(flg_wr), .flg_wdata(flg_wdata),
  .count_o(count_o), .wrap_o(wrap_o), .edge_o(edge_o), .irq_o(irq_o)
);

// File: tb/tb_pulse_accum.sv
module tb_pulse_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_i = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [4:0]  ctl_wdata = '0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        flg_wr = 1'b0;
  logic [1:0]  flg_wdata = '0;
  logic [15:0] count_o;
  logic        wrap_o, edge_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_cnt;

  always #5 clk = ~clk;

  pulse_accum dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .flg_wr(flg_wr), .flg_wdata(flg_wdata),
    .count_o(count_o), .wrap_o(wrap_o), .edge_o(edge_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(input logic en, input logic mode, input logic pol,
                         input logic wie, input logic eie);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {eie, wie, pol, mode, en};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic clr(input logic [1:0] v);
    @(negedge clk);
    flg_wr = 1'b1; flg_wdata = v;
    @(negedge clk);
    flg_wr = 1'b0;
  endtask

  // One active edge: pol=1 counts rising (idle low), pol=0 counts falling (idle high).
  task automatic pulse(input logic pol);
    @(negedge clk); pin_i = pol;  wait_n(4);
    pin_i = ~pol; wait_n(4);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 wrap", wrap_o, 0);
    check("R1 edge", edge_o, 0);
    check("R1 irq", irq_o, 0);

    // R2/R3 edge mode, both polarities, pulse counts 0..6
    for (int p = 0; p < 2; p++) begin
      logic pol;
      pol = logic'(p);
      pin_i = ~pol; wait_n(6);
      set_ctl(1, 0, pol, 0, 0);
      load(16'd0); clr(2'b11);
      exp_cnt = 0;
      for (int n = 0; n < 7; n++) begin
        for (int i = 0; i < n; i++) pulse(pol);
        exp_cnt = exp_cnt + 16'(n);
        check("R2 edge count", count_o, exp_cnt);
      end
      check("R3 edge flag set", edge_o, 1);
      clr(2'b01);
      // half pulse: active edge counts, opposite edge does not
      pin_i = pol; wait_n(5);
      check("R2 active edge", count_o, exp_cnt + 16'd1);
      check("R3 flag on active edge", edge_o, 1);
      clr(2'b01);
      pin_i = ~pol; wait_n(5);
      check("R2 opposite edge ignored", count_o, exp_cnt + 16'd1);
      check("R3 no flag on opposite edge", edge_o, 0);
    end

    // R4/R5 gated mode: windows of exactly 64*k active cycles
    for (int p = 0; p < 2; p++) begin
      logic pol, act;
      pol = logic'(p);
      act = ~pol;
      pin_i = ~act; wait_n(6);
      set_ctl(1, 1, pol, 0, 0);
      load(16'd0); clr(2'b11);
      exp_cnt = 0;
      for (int k = 1; k < 5; k++) begin
        @(negedge clk); pin_i = act;
        wait_n(9);
        check("R5 no flag on leading edge", edge_o, 0);
        wait_n(64 * k - 9);
        pin_i = ~act;
        wait_n(6);
        exp_cnt = exp_cnt + 16'(k);
        check("R4 gated count", count_o, exp_cnt);
        check("R5 flag on trailing edge", edge_o, 1);
        clr(2'b01);
      end
      wait_n(200);
      check("R4 inactive holds", count_o, exp_cnt);
    end

    // R6/R7/R9 wrap after exactly N events
    pin_i = 1'b0; wait_n(6);
    for (int j = 0; j < 3; j++) begin
      int n;
      n = (j == 0) ? 1 : (j == 1) ? 2 : 5;
      set_ctl(1, 0, 1, 0, 0);
      load(16'(32'h10000 - n)); clr(2'b11);
      for (int i = 0; i < n - 1; i++) pulse(1'b1);
      check("R7 no wrap before N", wrap_o, 0);
      pulse(1'b1);
      check("R6 wrap set", wrap_o, 1);
      check("R6 count zero", count_o, 0);
      check("R9 irq masked", irq_o, 0);
      set_ctl(1, 0, 1, 1, 0);
      check("R9 irq wrap", irq_o, 1);
      // R8 selective clears
      clr(2'b00);
      check("R8 zero write keeps wrap", wrap_o, 1);
      check("R8 zero write keeps edge", edge_o, 1);
      clr(2'b01);
      check("R8 edge cleared", edge_o, 0);
      check("R8 wrap kept", wrap_o, 1);
      clr(2'b10);
      check("R8 wrap cleared", wrap_o, 0);
      check("R9 irq dropped", irq_o, 0);
    end
    set_ctl(1, 0, 1, 0, 1);
    pulse(1'b1);
    check("R9 irq edge", irq_o, 1);
    set_ctl(1, 0, 1, 0, 0);
    check("R9 edge masked", irq_o, 0);

    // R10 disabled in both modes
    for (int m = 0; m < 2; m++) begin
      load(16'h1234); clr(2'b11);
      set_ctl(0, logic'(m), 1, 1, 1);
      for (int i = 0; i < 4; i++) pulse(1'b1);
      @(negedge clk); pin_i = 1'b0; wait_n(200);
      pin_i = 1'b1; wait_n(6); pin_i = 1'b0; wait_n(6);
      check("R10 count held", count_o, 16'h1234);
      check("R10 wrap held", wrap_o, 0);
      check("R10 edge held", edge_o, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule